// File: doc/BRIEF.md
# Nonexistent-Memory Fill Responder

This block sits between the system response port and the miss-handling logic of a processor's memory pipeline. A fill request that misses the caches can target a physical address with no memory or I/O behind it, and the system then answers with an error response instead of data. The responder resolves that case locally. Each load merged into the miss receives a word of all ones. Each store merged into the miss fails, and reports that failure the way an unsuccessful store-conditional does. The cache block at the miss index is invalidated by one atomic evict command. The responder handles a normal data response over the same path and applies none of those error actions.

The miss entry is presented together with the response. It holds the physical address, the cache index, a speculative flag, and up to a parameterised number of merged operations, each with a tag and a load/store kind. Once the responder accepts a response, it returns the merged operations one at a time in queue order. Each operation uses a valid/ready handshake. The evict command runs alongside these returns and waits for an acknowledge from the cache controller. The entry is freed only after every operation has been returned and the evict has completed. A speculative reference can come from a mispredicted path, so it must not set or lock system error state. For that reason the error-log pulse is produced only for non-speculative references.

Top module: `badaddr_fill_resp`

## Requirements
- R1: The response-ready output is high whenever no entry is in progress. A response is accepted in a cycle where response-valid and response-ready are both high, and the miss entry is captured at that edge. Response-ready stays low from the acceptance until the edge after the entry-free pulse.
- R2: Slot i of the entry is a load when bit i of the operation-kind mask is 0. The tag of slot i sits in bits [i*TW +: TW] of the tag bus. After an error response, every load slot is returned on the load port in ascending slot order, with its own tag and a data word of all ones.
- R3: Slot i is a store when bit i of the kind mask is 1. After an error response, every store slot is reported on the store-completion port in ascending slot order (shared with loads), with its tag and the fail flag set to 1.
- R4: After a normal response (error flag 0), loads receive the response data unchanged and stores report fail flag 0. No evict command and no error-log pulse are produced.
- R5: After an error response, an evict command is raised in the cycle after acceptance, carrying the captured cache index. It is held with a stable index until the cycle in which the acknowledge is high.
- R6: No new response is accepted while an evict is pending. The entry-free pulse comes only after all slots have been returned and the evict has been acknowledged, and it is produced exactly once per accepted response.
- R7: For a non-speculative error response, the error-log valid output is high for exactly one cycle, in the cycle after acceptance, and carries the captured physical address.
- R8: A speculative error response produces no error-log pulse. Apart from that, the speculative flag has no effect on the data, fail flags, evict command or ordering.
- R9: An operation count of 0 returns nothing. A count above the slot capacity NOPS is treated as NOPS.
- R10: While a load or store return is valid and its ready input is low, the valid output, the tag and the data/fail value stay unchanged. Load and store returns are never valid in the same cycle.
- R11: After reset, response-ready is high and load-valid, store-valid, evict-valid, error-log valid and entry-free are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| respValid | input | 1 | System response present |
| respErr | input | 1 | Response is a read-data error (nonexistent address) |
| respData | input | DW | Response data for a normal fill |
| respReady | output | 1 | Responder can accept a response |
| missAddr | input | AW | Physical address of the miss entry |
| missIndex | input | IXW | Cache index of the miss entry |
| missSpec | input | 1 | Miss was issued speculatively |
| missOpCount | input | CNTW | Number of merged operations |
| missOpStore | input | NOPS | Per-slot kind, 1 = store, 0 = load |
| missOpTag | input | NOPS*TW | Per-slot tags, slot i at [i*TW +: TW] |
| ldValid | output | 1 | Load return valid |
| ldReady | input | 1 | Load return accepted |
| ldTag | output | TW | Tag of the returned load |
| ldData | output | DW | Data for the returned load |
| stValid | output | 1 | Store completion valid |
| stReady | input | 1 | Store completion accepted |
| stTag | output | TW | Tag of the completed store |
| stFail | output | 1 | Store failed (store-conditional style) |
| evValid | output | 1 | Atomic evict command pending |
| evAck | input | 1 | Cache controller accepts the evict |
| evIndex | output | IXW | Index of the block to invalidate |
| logValid | output | 1 | One-cycle error-log pulse |
| logAddr | output | AW | Physical address for the error log |
| entryFree | output | 1 | Miss entry released this cycle |

## Verification
The assertions check the handshake properties on every cycle. These are the holding of a stalled load, store or evict return, the mutual exclusion of load and store returns, the absence of acceptance while an evict is pending, the single-cycle shape of the log pulse, and that the entry is never freed with an evict outstanding. The bench scenarios show the value-level behaviour, which no per-cycle property captures. This covers slot ordering and tags, all-ones versus pass-through data, the fail flag, count clamping, the speculative suppression of logging, and the exact cycle of the log pulse. The sweep covers every kind mask, every count including out-of-range ones, and both the error flag and the speculative flag, each under varying ready stalls and evict acknowledge delays.

// File: rtl/badaddr_fill_resp_pkg.sv
package badaddr_fill_resp_pkg;

  // Strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic capture;    // latch response and miss entry
    logic advance;    // current slot handed off, move to next
    logic freeEntry;  // entry released, rewind slot pointer
  } ctrlStrobes_t;

  // Status reported by the datapath to the control FSM
  typedef struct packed {
    logic slotDone;   // all merged operations returned
    logic curIsStore; // current slot is a store
    logic evPending;  // evict command not yet acknowledged
  } dpStatus_t;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } ctrlState_t;

endpackage

// File: rtl/badaddr_fill_resp_ctrl.sv
module badaddr_fill_resp_ctrl
  import badaddr_fill_resp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         respValid,
  input  logic         ldReady,
  input  logic         stReady,
  input  dpStatus_t    status,
  output ctrlStrobes_t strb,
  output logic         respReady,
  output logic         ldValid,
  output logic         stValid,
  output logic         entryFree
);

  ctrlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    respReady = 1'b0;
    ldValid   = 1'b0;
    stValid   = 1'b0;
    entryFree = 1'b0;
    unique case (state)
      ST_IDLE: begin
        respReady = 1'b1;
        if (respValid) begin
          strb.capture = 1'b1;
          nextState    = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!status.slotDone) begin
          if (status.curIsStore) begin
            stValid      = 1'b1;
            strb.advance = stReady;
          end else begin
            ldValid      = 1'b1;
            strb.advance = ldReady;
          end
        end else if (!status.evPending) begin
          entryFree      = 1'b1;
          strb.freeEntry = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/badaddr_fill_resp_dpath.sv
module badaddr_fill_resp_dpath
  import badaddr_fill_resp_pkg::*;
#(
  parameter int DW   = 64,
  parameter int AW   = 44,
  parameter int IXW  = 10,
  parameter int NOPS = 4,
  parameter int TW   = 4,
  parameter int CNTW = $clog2(NOPS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic             respErr,
  input  logic [DW-1:0]    respData,
  input  logic [AW-1:0]    missAddr,
  input  logic [IXW-1:0]   missIndex,
  input  logic             missSpec,
  input  logic [CNTW-1:0]  missOpCount,
  input  logic [NOPS-1:0]  missOpStore,
  input  logic [NOPS*TW-1:0] missOpTag,
  input  logic             evAck,
  output dpStatus_t        status,
  output logic [TW-1:0]    ldTag,
  output logic [DW-1:0]    ldData,
  output logic [TW-1:0]    stTag,
  output logic             stFail,
  output logic             evValid,
  output logic [IXW-1:0]   evIndex,
  output logic             logValid,
  output logic [AW-1:0]    logAddr
);

  localparam logic [CNTW-1:0] CapCount = CNTW'(NOPS);

  logic              entErr;
  logic [DW-1:0]     entData;
  logic [IXW-1:0]    entIndex;
  logic [CNTW-1:0]   opCount;
  logic [CNTW-1:0]   slotIdx;
  logic [NOPS-1:0]   storeMask;
  logic              evPend;
  logic [TW-1:0]     tagArr [NOPS];
  logic [TW-1:0]     curTag;
  logic              curStore;
  logic [CNTW-1:0]   clampedCount;

  assign clampedCount = (missOpCount > CapCount) ? CapCount : missOpCount;

  // Entry capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entErr    <= 1'b0;
      entData   <= '0;
      entIndex  <= '0;
      opCount   <= '0;
      storeMask <= '0;
      logAddr   <= '0;
    end else if (strb.capture) begin
      entErr    <= respErr;
      entData   <= respData;
      entIndex  <= missIndex;
      opCount   <= clampedCount;
      storeMask <= missOpStore;
      logAddr   <= missAddr;
    end
  end

  // Per-slot tag storage
  for (genvar g = 0; g < NOPS; g++) begin : gTag
    always_ff @(posedge clk) begin
      if (!rstN)             tagArr[g] <= '0;
      else if (strb.capture) tagArr[g] <= missOpTag[g*TW +: TW];
    end
  end

  // Slot pointer
  always_ff @(posedge clk) begin
    if (!rstN || strb.freeEntry || strb.capture) slotIdx <= '0;
    else if (strb.advance)                       slotIdx <= slotIdx + CNTW'(1);
  end

  // Evict command state
  always_ff @(posedge clk) begin
    if (!rstN)             evPend <= 1'b0;
    else if (strb.capture) evPend <= respErr;
    else if (evAck)        evPend <= 1'b0;
  end

  // Error-log pulse, suppressed for speculative references
  always_ff @(posedge clk) begin
    if (!rstN) logValid <= 1'b0;
    else       logValid <= strb.capture && respErr && !missSpec;
  end

  // Current slot select
  always_comb begin
    curTag   = '0;
    curStore = 1'b0;
    for (int i = 0; i < NOPS; i++) begin
      if (slotIdx == CNTW'(i)) begin
        curTag   = tagArr[i];
        curStore = storeMask[i];
      end
    end
  end

  assign status.slotDone   = (slotIdx >= opCount);
  assign status.curIsStore = curStore;
  assign status.evPending  = evPend;

  assign ldTag   = curTag;
  assign stTag   = curTag;
  assign ldData  = entErr ? {DW{1'b1}} : entData;
  assign stFail  = entErr;
  assign evValid = evPend;
  assign evIndex = entIndex;

endmodule

// File: rtl/badaddr_fill_resp.sv
module badaddr_fill_resp
  import badaddr_fill_resp_pkg::*;
#(
  parameter int DW   = 64,
  parameter int AW   = 44,
  parameter int IXW  = 10,
  parameter int NOPS = 4,
  parameter int TW   = 4,
  parameter int CNTW = $clog2(NOPS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               respValid,
  input  logic               respErr,
  input  logic [DW-1:0]      respData,
  output logic               respReady,
  input  logic [AW-1:0]      missAddr,
  input  logic [IXW-1:0]     missIndex,
  input  logic               missSpec,
  input  logic [CNTW-1:0]    missOpCount,
  input  logic [NOPS-1:0]    missOpStore,
  input  logic [NOPS*TW-1:0] missOpTag,
  output logic               ldValid,
  input  logic               ldReady,
  output logic [TW-1:0]      ldTag,
  output logic [DW-1:0]      ldData,
  output logic               stValid,
  input  logic               stReady,
  output logic [TW-1:0]      stTag,
  output logic               stFail,
  output logic               evValid,
  input  logic               evAck,
  output logic [IXW-1:0]     evIndex,
  output logic               logValid,
  output logic [AW-1:0]      logAddr,
  output logic               entryFree
);

  ctrlStrobes_t strb;
  dpStatus_t    status;

  badaddr_fill_resp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .respValid (respValid),
    .ldReady   (ldReady),
    .stReady   (stReady),
    .status    (status),
    .strb      (strb),
    .respReady (respReady),
    .ldValid   (ldValid),
    .stValid   (stValid),
    .entryFree (entryFree)
  );

  badaddr_fill_resp_dpath #(
    .DW(DW), .AW(AW), .IXW(IXW), .NOPS(NOPS), .TW(TW), .CNTW(CNTW)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .respErr     (respErr),
    .respData    (respData),
    .missAddr    (missAddr),
    .missIndex   (missIndex),
    .missSpec    (missSpec),
    .missOpCount (missOpCount),
    .missOpStore (missOpStore),
    .missOpTag   (missOpTag),
    .evAck       (evAck),
    .status      (status),
    .ldTag       (ldTag),
    .ldData      (ldData),
    .stTag       (stTag),
    .stFail      (stFail),
    .evValid     (evValid),
    .evIndex     (evIndex),
    .logValid    (logValid),
    .logAddr     (logAddr)
  );

endmodule

// File: rtl/badaddr_fill_resp_chk.sv
module badaddr_fill_resp_chk #(
  parameter int DW  = 64,
  parameter int IXW = 10,
  parameter int TW  = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           respReady,
  input logic           ldValid,
  input logic           ldReady,
  input logic [TW-1:0]  ldTag,
  input logic [DW-1:0]  ldData,
  input logic           stValid,
  input logic           stReady,
  input logic [TW-1:0]  stTag,
  input logic           stFail,
  input logic           evValid,
  input logic           evAck,
  input logic [IXW-1:0] evIndex,
  input logic           logValid,
  input logic           entryFree
);

  a_r10_ld_hold: assert property (@(posedge clk) disable iff (!rstN)
    ldValid && !ldReady |=> ldValid && $stable(ldTag) && $stable(ldData));

  a_r10_st_hold: assert property (@(posedge clk) disable iff (!rstN)
    stValid && !stReady |=> stValid && $stable(stTag) && $stable(stFail));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ldValid && stValid));

  a_r5_ev_hold: assert property (@(posedge clk) disable iff (!rstN)
    evValid && !evAck |=> evValid && $stable(evIndex));

  a_r6_no_accept_evict: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> !respReady);

  a_r6_free_after_evict: assert property (@(posedge clk) disable iff (!rstN)
    entryFree |-> !evValid && !ldValid && !stValid);

  a_r7_log_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    logValid |=> !logValid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    respReady |-> !ldValid && !stValid && !entryFree);

endmodule

bind badaddr_fill_resp badaddr_fill_resp_chk #(.DW(DW), .IXW(IXW), .TW(TW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .respReady (respReady),
  .ldValid   (ldValid),
  .ldReady   (ldReady),
  .ldTag     (ldTag),
  .ldData    (ldData),
  .stValid   (stValid),
  .stReady   (stReady),
  .stTag     (stTag),
  .stFail    (stFail),
  .evValid   (evValid),
  .evAck     (evAck),
  .evIndex   (evIndex),
  .logValid  (logValid),
  .entryFree (entryFree)
);

// File: tb/sim_badaddr_fill_resp.sv
module sim_badaddr_fill_resp;

  localparam int DW = 64, AW = 44, IXW = 10, NOPS = 4, TW = 4;
  localparam int CNTW = $clog2(NOPS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic respValid = 1'b0, respErr = 1'b0;
  logic [DW-1:0] respData = '0;
  logic respReady;
  logic [AW-1:0] missAddr = '0;
  logic [IXW-1:0] missIndex = '0;
  logic missSpec = 1'b0;
  logic [CNTW-1:0] missOpCount = '0;
  logic [NOPS-1:0] missOpStore = '0;
  logic [NOPS*TW-1:0] missOpTag = '0;
  logic ldValid, ldReady = 1'b0;
  logic [TW-1:0] ldTag;
  logic [DW-1:0] ldData;
  logic stValid, stReady = 1'b0;
  logic [TW-1:0] stTag;
  logic stFail;
  logic evValid, evAck = 1'b0;
  logic [IXW-1:0] evIndex;
  logic logValid;
  logic [AW-1:0] logAddr;
  logic entryFree;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  badaddr_fill_resp #(.DW(DW), .AW(AW), .IXW(IXW), .NOPS(NOPS), .TW(TW)) u0 (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] tagOf(input int run, input int slot);
    return TW'((run * 3 + slot * 5 + 1) & 15);
  endfunction

  task automatic runOne(input int run, input int cnt, input int mask,
                        input bit err, input bit spec, input int dly);
    int eff, slot, evWait, logCnt, evCnt, freeCnt, iter;
    logic [DW-1:0] dataVal, expData;
    logic [AW-1:0] addrVal;
    logic [IXW-1:0] idxVal;
    bit done;
    eff = (cnt > NOPS) ? NOPS : cnt;
    dataVal = {32'(run) * 32'h9E3779B1, 32'(run) ^ 32'h5A5A_0000};
    addrVal = AW'(run) * 44'h1_0040 + 44'h3F8;
    idxVal = IXW'(run * 7 + 3);
    expData = err ? {DW{1'b1}} : dataVal;

    @(negedge clk);
    respValid = 1'b1; respErr = err; respData = dataVal;
    missAddr = addrVal; missIndex = idxVal; missSpec = spec;
    missOpCount = CNTW'(cnt); missOpStore = NOPS'(mask);
    for (int i = 0; i < NOPS; i++) missOpTag[i*TW +: TW] = tagOf(run, i);
    #1;
    check(respReady === 1'b1, "R1", "ready when idle", 64'(respReady), 64'd1);
    @(negedge clk);
    respValid = 1'b0; respErr = 1'b0; respData = '0; missSpec = 1'b0;

    slot = 0; evWait = 0; logCnt = 0; evCnt = 0; freeCnt = 0; done = 0; iter = 0;
    while (!done && iter < 60) begin
      ldReady = ((iter + run) % 3) != 0;
      stReady = ((iter + run) % 4) != 1;
      evAck = evValid && (evWait >= dly);
      #1;
      if (iter == 0)
        check(logValid === (err && !spec), spec ? "R8" : "R7", "log pulse after accept",
              64'(logValid), 64'(err && !spec));
      if (logValid) begin
        logCnt++;
        check(logAddr === addrVal, "R7", "log address", 64'(logAddr), 64'(addrVal));
      end
      if (!entryFree)
        check(respReady === 1'b0, evValid ? "R6" : "R1", "no accept while busy",
              64'(respReady), 64'd0);
      if (evValid) begin
        check(err === 1'b1, "R4", "evict only on error", 64'(evValid), 64'd0);
        check(evIndex === idxVal, "R5", "evict index", 64'(evIndex), 64'(idxVal));
        if (evAck) evCnt++;
        evWait++;
      end
      if (ldValid) begin
        check(slot < eff && !mask[slot], "R9", "load slot in range", 64'(slot), 64'(eff));
        check(ldTag === tagOf(run, slot), "R2", "load tag order", 64'(ldTag), 64'(tagOf(run, slot)));
        check(ldData === expData, err ? "R2" : "R4", "load data", ldData, expData);
        if (!ldReady)
          check(!stValid, "R10", "held load excludes store", 64'(stValid), 64'd0);
        if (ldReady) slot++;
      end else if (stValid) begin
        check(slot < eff && mask[slot], "R9", "store slot in range", 64'(slot), 64'(eff));
        check(stTag === tagOf(run, slot), "R3", "store tag order", 64'(stTag), 64'(tagOf(run, slot)));
        check(stFail === err, err ? "R3" : "R4", "store fail flag", 64'(stFail), 64'(err));
        if (stReady) slot++;
      end
      if (entryFree) begin
        freeCnt++;
        done = 1;
        check(slot == eff, "R6", "free after all slots", 64'(slot), 64'(eff));
        check(evCnt == (err ? 1 : 0), "R6", "free after evict ack", 64'(evCnt), 64'(err));
      end
      @(negedge clk);
      iter++;
    end
    ldReady = 1'b0; stReady = 1'b0; evAck = 1'b0;
    #1;
    check(done, "R6", "entry freed", 64'(done), 64'd1);
    check(logCnt == ((err && !spec) ? 1 : 0), spec ? "R8" : "R7", "log pulse count",
          64'(logCnt), 64'(err && !spec));
    check(respReady === 1'b1, "R1", "ready after free", 64'(respReady), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(respReady === 1'b1 && !ldValid && !stValid && !evValid && !logValid && !entryFree,
          "R11", "reset outputs",
          64'({respReady, ldValid, stValid, evValid, logValid, entryFree}), 64'h20);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(respReady === 1'b1 && !evValid, "R11", "outputs after reset release",
          64'({respReady, evValid}), 64'h2);
    begin
      int run;
      run = 0;
      for (int cnt = 0; cnt < (1 << CNTW); cnt++)
        for (int mask = 0; mask < (1 << NOPS); mask++)
          for (int ev = 0; ev < 4; ev++) begin
            runOne(run, cnt, mask, ev[0], ev[1], run % 4);
            run++;
          end
    end
    finished = 1;
  end

  initial begin
    wait (finished || cycles > 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule